// File: doc/BRIEF.md
# Floating-Point Status Register Issue Interlock

This block sits between instruction decode and the floating-point issue port. For each decoded instruction it decides whether the instruction may leave decode this cycle. An instruction that reads or writes the floating-point status and control register may start only once all older floating-point work has drained. Drained means three things: no floating-point operation is still in flight, no raised exception is still waiting to be recorded, and no exception-handler request is still waiting to be taken.

While such a status-register instruction executes, the block holds a busy flag. Younger floating-point instructions that depend on or change status bits wait until that flag clears. Younger arithmetic that does not touch status bits, floating-point loads and stores, and non-floating-point instructions pass freely.

The block tracks its state with three saturating level counters and one flag. The counters follow the FPU's issue and completion pulses, the exception raise and record pulses, and the handler request and taken pulses. The flag is set when a status-register instruction is accepted and cleared by its completion pulse. The ready and stall outputs are combinational from this state and from the current decode inputs.

Top module: `fstat_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all counters are zero and the busy flag is clear, so a status-register instruction (class code 2'b10) is ready at once.
- R2: A status-register instruction is not ready while the in-flight count is nonzero. The count rises on each `fpu_issue_i` pulse and falls on each `fpu_done_i` pulse.
- R3: A status-register instruction is not ready while the number of `exc_raise_i` pulses exceeds the number of `exc_rec_i` pulses.
- R4: A status-register instruction is not ready while the number of `hdl_req_i` pulses exceeds the number of `hdl_taken_i` pulses.
- R5: After a status-register instruction is accepted, an arithmetic instruction (class 2'b00) with `dec_touch_i` high is not ready. It becomes ready in the cycle after a `stat_done_i` pulse.
- R6: An arithmetic instruction with `dec_touch_i` low is ready while a status-register instruction executes.
- R7: A floating-point memory instruction (class 2'b01) is always ready, whatever the counters and busy flag hold.
- R8: A second status-register instruction is not ready while the first one still executes.
- R9: When an increment and a decrement pulse of the same counter arrive in the same cycle, the count does not change.
- R10: `stall_o` is high exactly when `dec_valid_i` is high and `dec_ready_o` is low, in the same cycle.
- R11: A non-floating-point instruction (class 2'b11) is always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_class_i | input | 2 | Class code: 00 arithmetic, 01 memory, 10 status register, 11 other |
| dec_touch_i | input | 1 | Instruction depends on or alters status bits |
| dec_ready_o | output | 1 | Instruction may leave decode this cycle |
| stall_o | output | 1 | Valid instruction held in decode |
| fpu_issue_i | input | 1 | Pulse: one floating-point operation entered the FPU |
| fpu_done_i | input | 1 | Pulse: one floating-point operation completed |
| exc_raise_i | input | 1 | Pulse: an exception was raised |
| exc_rec_i | input | 1 | Pulse: an exception was recorded in the status register |
| hdl_req_i | input | 1 | Pulse: an exception-handler invocation was requested |
| hdl_taken_i | input | 1 | Pulse: a requested handler invocation occurred |
| stat_done_i | input | 1 | Pulse: the executing status-register instruction completed |

## Verification
Two pairs of events can land in the same cycle. The first pair is an increment and a decrement of one tracking counter. The bench drives issue with completion, and raise with record, on the same edge. A wrong count then shows up as an early or late ready on a following status-register instruction. The second pair is the completion of a status-register instruction arriving in the cycle that a status-touching arithmetic instruction is held. The bench checks that the held instruction is still stalled in that cycle and ready in the next.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_MEM   = 2'b01,
    CLS_STAT  = 2'b10,
    CLS_OTHER = 2'b11
  } icls_e;
endpackage

// File: rtl/fstat_level_cnt.sv
module fstat_level_cnt #(
  parameter int unsigned MAX = 15,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] lvl_q;

  // simultaneous inc/dec cancel; saturate at both ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (inc_i && !dec_i && lvl_q != W'(MAX)) begin
      lvl_q <= lvl_q + W'(1);
    end else if (dec_i && !inc_i && lvl_q != '0) begin
      lvl_q <= lvl_q - W'(1);
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/fstat_issue_gate.sv
module fstat_issue_gate
  import fstat_pkg::*;
(
  input  logic [1:0] class_i,
  input  logic       touch_i,
  input  logic       busy_i,
  input  logic       drained_i,
  output logic       ready_o
);
  icls_e cls;
  assign cls = icls_e'(class_i);

  always_comb begin
    unique case (cls)
      CLS_ARITH: ready_o = !(busy_i && touch_i);
      CLS_STAT:  ready_o = drained_i && !busy_i;
      CLS_MEM:   ready_o = 1'b1;
      default:   ready_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fstat_serializer.sv
module fstat_serializer
  import fstat_pkg::*;
#(
  parameter int unsigned INFLIGHT_MAX = 15,
  parameter int unsigned EXC_MAX      = 7,
  parameter int unsigned HDL_MAX      = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dec_valid_i,
  input  logic [1:0] dec_class_i,
  input  logic       dec_touch_i,
  output logic       dec_ready_o,
  output logic       stall_o,
  input  logic       fpu_issue_i,
  input  logic       fpu_done_i,
  input  logic       exc_raise_i,
  input  logic       exc_rec_i,
  input  logic       hdl_req_i,
  input  logic       hdl_taken_i,
  input  logic       stat_done_i
);
  localparam int unsigned NCNT    = 3;
  localparam int unsigned CAP_A   = (INFLIGHT_MAX > EXC_MAX) ? INFLIGHT_MAX : EXC_MAX;
  localparam int unsigned CAP_MAX = (CAP_A > HDL_MAX) ? CAP_A : HDL_MAX;
  localparam int unsigned LW      = $clog2(CAP_MAX + 1);
  localparam int unsigned CAP [NCNT] = '{INFLIGHT_MAX, EXC_MAX, HDL_MAX};

  logic [NCNT-1:0] cnt_inc, cnt_dec, cnt_zero;
  logic [LW-1:0]   cnt_lvl [NCNT];
  logic            drained, busy_q, stat_accept;

  // index 0: in-flight ops, 1: unrecorded exceptions, 2: untaken handler requests
  assign cnt_inc = {hdl_req_i,   exc_raise_i, fpu_issue_i};
  assign cnt_dec = {hdl_taken_i, exc_rec_i,   fpu_done_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int unsigned CW = $clog2(CAP[g] + 1);
    logic [CW-1:0] lvl;
    fstat_level_cnt #(.MAX(CAP[g])) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (cnt_inc[g]),
      .dec_i   (cnt_dec[g]),
      .level_o (lvl)
    );
    assign cnt_lvl[g]  = LW'(lvl);
    assign cnt_zero[g] = (lvl == '0);
  end

  assign drained = &cnt_zero;

  fstat_issue_gate u_gate (
    .class_i   (dec_class_i),
    .touch_i   (dec_touch_i),
    .busy_i    (busy_q),
    .drained_i (drained),
    .ready_o   (dec_ready_o)
  );

  assign stall_o     = dec_valid_i && !dec_ready_o;
  assign stat_accept = dec_valid_i && dec_ready_o && (dec_class_i == CLS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (stat_accept) begin
      busy_q <= 1'b1;
    end else if (stat_done_i) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fstat_serializer_chk.sv
module fstat_serializer_chk #(
  parameter int unsigned LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic [1:0]    dec_class_i,
  input logic          dec_touch_i,
  input logic          dec_ready_o,
  input logic          fpu_issue_i,
  input logic          fpu_done_i,
  input logic          stat_done_i,
  input logic          busy_q,
  input logic [2:0]    cnt_zero,
  input logic [LW-1:0] infl_lvl
);
  p_stat_drained_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_class_i == 2'b10 && dec_ready_o) |-> cnt_zero[0]);

  p_stat_recorded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_class_i == 2'b10 && dec_ready_o) |-> cnt_zero[1]);

  p_stat_handled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_class_i == 2'b10 && dec_ready_o) |-> cnt_zero[2]);

  p_touch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dec_class_i == 2'b00 && dec_touch_i) |-> !dec_ready_o);

  p_busy_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(stat_done_i));

  p_plain_arith_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_class_i == 2'b00 && !dec_touch_i) |-> dec_ready_o);

  p_mem_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_class_i == 2'b01) |-> dec_ready_o);

  p_single_stat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dec_class_i == 2'b10) |-> !dec_ready_o);

  p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpu_issue_i && fpu_done_i) |=> $stable(infl_lvl));

  p_other_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_class_i == 2'b11) |-> dec_ready_o);
endmodule

bind fstat_serializer fstat_serializer_chk #(.LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .dec_class_i (dec_class_i),
  .dec_touch_i (dec_touch_i),
  .dec_ready_o (dec_ready_o),
  .fpu_issue_i (fpu_issue_i),
  .fpu_done_i  (fpu_done_i),
  .stat_done_i (stat_done_i),
  .busy_q      (busy_q),
  .cnt_zero    (cnt_zero),
  .infl_lvl    (cnt_lvl[0])
);

// File: tb/fstat_serializer_bench.sv
`timescale 1ns/1ps
module fstat_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0, t = 1'b0, iss = 1'b0, dn = 1'b0;
  logic       er = 1'b0, ec = 1'b0, hr = 1'b0, ht = 1'b0, sd = 1'b0;
  logic [1:0] cls = 2'b00;
  logic       rdy, stl;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  fstat_serializer u_fstat_serializer (
    .clk_i (clk), .rst_ni (rst_n),
    .dec_valid_i (v), .dec_class_i (cls), .dec_touch_i (t),
    .dec_ready_o (rdy), .stall_o (stl),
    .fpu_issue_i (iss), .fpu_done_i (dn),
    .exc_raise_i (er), .exc_rec_i (ec),
    .hdl_req_i (hr), .hdl_taken_i (ht), .stat_done_i (sd)
  );

  // {v, cls[1:0], touch, iss, done, raise, rec, hreq, htaken, sdone, exp_ready, exp_stall}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_10_0_00_00_00_0_10, // R1 status accepted from idle
    13'b1_00_1_00_00_00_0_01, // R5 touch arith held
    13'b1_00_0_10_00_00_0_10, // R6 plain arith passes, issue
    13'b1_01_0_00_00_00_1_10, // R7 memory passes, status done
    13'b1_10_0_11_00_00_0_01, // R2 in flight; R9 issue+done
    13'b1_10_0_01_00_00_0_01, // R9 count kept at one
    13'b0_10_0_00_10_00_0_10, // R10 no valid, no stall; raise
    13'b1_10_0_00_11_00_0_01, // R3 unrecorded; raise+rec
    13'b1_10_0_00_01_10_0_01, // R3 still one; rec, hreq
    13'b1_10_0_00_00_01_0_01, // R4 handler pending; taken
    13'b1_10_0_00_00_00_0_10, // R4 released, status accepted
    13'b1_10_0_00_00_00_0_01, // R8 second status held
    13'b1_11_1_00_00_00_0_10, // R11 other class passes
    13'b1_00_1_00_00_00_1_01, // R5 still held in done cycle
    13'b1_00_1_10_00_00_0_10, // R5 released next cycle
    13'b1_00_1_01_00_00_0_10  // R2 arith ignores in-flight
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R5";  2: return "R6";  3: return "R7";
      4: return "R2";  5: return "R9";  6: return "R10"; 7: return "R3";
      8: return "R3";  9: return "R4";  10: return "R4"; 11: return "R8";
      12: return "R11"; 13: return "R5"; 14: return "R5"; default: return "R2";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    v = 0; cls = 2'b00; t = 0; iss = 0; dn = 0;
    er = 0; ec = 0; hr = 0; ht = 0; sd = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    // R1: state during reset
    v = 1; cls = 2'b10;
    #1;
    check("R1", "ready in reset", rdy, 1'b1);
    check("R10", "stall in reset", stl, 1'b0);
    v = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {v, cls, t, iss, dn, er, ec, hr, ht, sd} = VEC[i][12:2];
      #1;
      check(tag_of(i), $sformatf("vec%0d ready", i), rdy, VEC[i][1]);
      check(tag_of(i), $sformatf("vec%0d stall", i), stl, VEC[i][0]);
    end

    // corner: load all state, then reset mid-operation
    @(negedge clk); idle_inputs();
    v = 1; cls = 2'b10;                  // accept status, busy set
    @(negedge clk); idle_inputs();
    iss = 1; er = 1; hr = 1;
    @(negedge clk); idle_inputs();
    v = 1; cls = 2'b00; t = 1;
    #1;
    check("R5", "busy before reset", rdy, 1'b0);
    check("R10", "stall when held", stl, 1'b1);
    v = 0;
    #1;
    check("R10", "no stall without valid", stl, 1'b0);
    rst_n = 1'b0;
    #1;
    v = 1; cls = 2'b10;
    #1;
    check("R1", "status ready in reset", rdy, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1", "status ready after reset", rdy, 1'b1);
    cls = 2'b00; t = 1;
    #1;
    check("R1", "touch arith ready after reset", rdy, 1'b1);

    // R7: memory passes with busy and in-flight both set
    @(negedge clk); idle_inputs(); v = 1; cls = 2'b10;
    @(negedge clk); idle_inputs(); iss = 1;
    @(negedge clk); idle_inputs(); v = 1; cls = 2'b01;
    #1;
    check("R7", "memory under load", rdy, 1'b1);
    cls = 2'b10;
    #1;
    check("R8", "status while busy and in flight", rdy, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule